// File: doc/BRIEF.md
# Reset Command Packet Decoder

This block watches a received Ethernet payload that arrives one byte per clock on a stream with `valid_i` and `last_i`. It recognises two reset commands by the packet type byte. A hard reset pulses the Ethernet controller reset and the reload of the board's own MAC address. A soft reset carries the host's MAC address, a debug byte and a per-chip reset mask. It pulses the SPI and DAC resets that the mask selects.

Every reset that completes is followed by a status-reply request. This request is a level that the frame builder acknowledges. The location byte of the command is latched for the reply, so the host can pair the board's source MAC with its slot. Packets of any other type pass through with no side effect.

Top module: `rst_cmd_decoder`

## Requirements
- R1: After reset all strobes and `status_req_o` are low, and `location_o`, `partner_mac_o` and `debug_o` are zero.
- R2: A type byte of 0x52 at payload index 1 makes `ec_rst_o` and `mac_reload_o` each go high for exactly one cycle, in the cycle after that byte is accepted.
- R3: A type byte of 0xD2 at index 1 starts a soft reset. Indices 2..7 carry the host MAC, with index 2 as bits 47:40 of `partner_mac_o`. Index 8 is the debug byte and index 9 is the mask byte. `partner_mac_o` is updated when the mask byte is accepted.
- R4: On the soft-reset mask byte, bit 1 gives a one-cycle `spi_rst_o` pulse and bit 0 gives a one-cycle `dac_rst_o` pulse, in the cycle after the mask byte. Mask bits 7:2 have no effect. A soft reset never pulses `ec_rst_o` or `mac_reload_o`.
- R5: `status_req_o` rises two cycles after the byte that completes a hard or soft command. This holds for a soft reset with a zero mask too.
- R6: `status_req_o` stays high until `status_ack_i` is sampled high, and is low in the following cycle.
- R7: A packet with any other type byte causes no strobe and no status request, and leaves `location_o`, `partner_mac_o` and `debug_o` unchanged.
- R8: A soft-reset packet whose last byte comes before the mask byte fires nothing and changes none of the latched outputs.
- R9: `location_o` shows payload byte 0 of the most recent completed reset packet.
- R10: `debug_o` shows the debug byte of the most recent completed soft reset and has no effect on any strobe.
- R11: Cycles with `valid_i` low do not advance the byte index. Bytes after the command point are ignored until `last_i`, even if they repeat a type code. A new packet starts on the byte after one accepted with `last_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_i | input | 8 | Payload byte |
| valid_i | input | 1 | `byte_i` is valid this cycle |
| last_i | input | 1 | Final byte of the payload |
| status_ack_i | input | 1 | Status reply accepted |
| ec_rst_o | output | 1 | Ethernet controller reset strobe |
| mac_reload_o | output | 1 | Own MAC address reload strobe |
| spi_rst_o | output | 1 | SPI bus reset strobe |
| dac_rst_o | output | 1 | DAC reset strobe |
| status_req_o | output | 1 | Status reply requested (level) |
| location_o | output | 8 | Location byte of the last reset command |
| partner_mac_o | output | 48 | Host MAC from the last soft reset |
| debug_o | output | 8 | Debug byte from the last soft reset |

## Verification
A wrong byte index or a stale packet-kind register shows up within the same packet. It appears as a missing or extra strobe, or as a MAC field with its octets shifted, one or two cycles after the command byte. A faulty pending stage shows as `status_req_o` rising one cycle early or late, or never rising. The sweeps cover every type code, every mask value, every truncation point and `valid_i` bubbles, so each such fault appears at the ports before the next packet begins.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  typedef enum logic [1:0] {
    PK_IDLE,
    PK_HARD,
    PK_SOFT,
    PK_SKIP
  } pkt_kind_e;

  localparam int LOC_IDX      = 0;
  localparam int TYPE_IDX     = 1;
  localparam int MAC_IDX      = 2;
  localparam int SPI_MASK_BIT = 1;
  localparam int DAC_MASK_BIT = 0;
endpackage

// File: rtl/rcd_cursor.sv
module rcd_cursor #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             last_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o <= '0;
    end else if (valid_i) begin
      if (last_i)                idx_o <= '0;
      else if (idx_o != IDX_MAX) idx_o <= idx_o + 1'b1;  // saturate on long payloads
    end
  end
endmodule

// File: rtl/rcd_fields.sv
module rcd_fields
  import rcd_pkg::*;
#(
  parameter int         MAC_BYTES = 6,
  parameter int         IDX_W     = 4,
  parameter logic [7:0] HARD_TYPE = 8'h52,
  parameter logic [7:0] SOFT_TYPE = 8'hD2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   last_i,
  input  logic [7:0]             byte_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic                   hard_cmt_o,
  output logic                   soft_cmt_o,
  output logic                   spi_sel_o,
  output logic                   dac_sel_o,
  output logic [7:0]             location_o,
  output logic [MAC_BYTES*8-1:0] partner_mac_o,
  output logic [7:0]             debug_o
);
  localparam int DBG_IDX  = MAC_IDX + MAC_BYTES;
  localparam int MASK_IDX = DBG_IDX + 1;
  localparam logic [IDX_W-1:0] I_LOC  = IDX_W'(LOC_IDX);
  localparam logic [IDX_W-1:0] I_TYPE = IDX_W'(TYPE_IDX);
  localparam logic [IDX_W-1:0] I_DBG  = IDX_W'(DBG_IDX);
  localparam logic [IDX_W-1:0] I_MASK = IDX_W'(MASK_IDX);

  pkt_kind_e              kind_q;
  logic [7:0]             loc_sh;
  logic [7:0]             dbg_sh;
  logic [7:0]             mac_sh [MAC_BYTES];
  logic [MAC_BYTES*8-1:0] mac_flat;

  function automatic pkt_kind_e classify(input logic [7:0] t);
    if (t == HARD_TYPE)      return PK_HARD;
    else if (t == SOFT_TYPE) return PK_SOFT;
    else                     return PK_SKIP;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          kind_q <= PK_IDLE;
    else if (valid_i && last_i)           kind_q <= PK_IDLE;
    else if (valid_i && idx_i == I_TYPE)  kind_q <= classify(byte_i);
  end

  assign hard_cmt_o = valid_i && (idx_i == I_TYPE) && (byte_i == HARD_TYPE);
  assign soft_cmt_o = valid_i && (idx_i == I_MASK) && (kind_q == PK_SOFT);
  assign spi_sel_o  = byte_i[SPI_MASK_BIT];
  assign dac_sel_o  = byte_i[DAC_MASK_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loc_sh <= '0;
      dbg_sh <= '0;
    end else if (valid_i) begin
      if (idx_i == I_LOC) loc_sh <= byte_i;
      if (idx_i == I_DBG) dbg_sh <= byte_i;
    end
  end

  // first MAC octet on the wire lands in the top octet
  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_mac
    localparam logic [IDX_W-1:0] I_OCT = IDX_W'(MAC_IDX + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        mac_sh[g] <= '0;
      else if (valid_i && idx_i == I_OCT) mac_sh[g] <= byte_i;
    end
    assign mac_flat[(MAC_BYTES-1-g)*8 +: 8] = mac_sh[g];
  end

  // shadows become visible only when a command completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      location_o    <= '0;
      partner_mac_o <= '0;
      debug_o       <= '0;
    end else if (soft_cmt_o) begin
      location_o    <= loc_sh;
      partner_mac_o <= mac_flat;
      debug_o       <= dbg_sh;
    end else if (hard_cmt_o) begin
      location_o    <= loc_sh;
    end
  end
endmodule

// File: rtl/rcd_sequencer.sv
module rcd_sequencer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hard_cmt_i,
  input  logic soft_cmt_i,
  input  logic spi_sel_i,
  input  logic dac_sel_i,
  input  logic status_ack_i,
  output logic ec_rst_o,
  output logic mac_reload_o,
  output logic spi_rst_o,
  output logic dac_rst_o,
  output logic status_req_o
);
  logic stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ec_rst_o     <= 1'b0;
      mac_reload_o <= 1'b0;
      spi_rst_o    <= 1'b0;
      dac_rst_o    <= 1'b0;
      stage_q      <= 1'b0;
      status_req_o <= 1'b0;
    end else begin
      ec_rst_o     <= hard_cmt_i;
      mac_reload_o <= hard_cmt_i;
      spi_rst_o    <= soft_cmt_i & spi_sel_i;
      dac_rst_o    <= soft_cmt_i & dac_sel_i;
      stage_q      <= hard_cmt_i | soft_cmt_i;
      // a new completion wins over a coincident acknowledge
      if (stage_q)           status_req_o <= 1'b1;
      else if (status_ack_i) status_req_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_cmd_decoder.sv
module rst_cmd_decoder
  import rcd_pkg::*;
#(
  parameter int         MAC_BYTES = 6,
  parameter logic [7:0] HARD_TYPE = 8'h52,
  parameter logic [7:0] SOFT_TYPE = 8'hD2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [7:0]             byte_i,
  input  logic                   valid_i,
  input  logic                   last_i,
  input  logic                   status_ack_i,
  output logic                   ec_rst_o,
  output logic                   mac_reload_o,
  output logic                   spi_rst_o,
  output logic                   dac_rst_o,
  output logic                   status_req_o,
  output logic [7:0]             location_o,
  output logic [MAC_BYTES*8-1:0] partner_mac_o,
  output logic [7:0]             debug_o
);
  localparam int LAST_CMD_IDX = MAC_IDX + MAC_BYTES + 1;
  localparam int IDX_W        = $clog2(LAST_CMD_IDX + 2);

  logic [IDX_W-1:0] idx;
  logic             hard_cmt, soft_cmt, spi_sel, dac_sel;

  rcd_cursor #(.IDX_W(IDX_W)) u_cursor (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .last_i  (last_i),
    .idx_o   (idx)
  );

  rcd_fields #(
    .MAC_BYTES (MAC_BYTES),
    .IDX_W     (IDX_W),
    .HARD_TYPE (HARD_TYPE),
    .SOFT_TYPE (SOFT_TYPE)
  ) u_fields (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (valid_i),
    .last_i        (last_i),
    .byte_i        (byte_i),
    .idx_i         (idx),
    .hard_cmt_o    (hard_cmt),
    .soft_cmt_o    (soft_cmt),
    .spi_sel_o     (spi_sel),
    .dac_sel_o     (dac_sel),
    .location_o    (location_o),
    .partner_mac_o (partner_mac_o),
    .debug_o       (debug_o)
  );

  rcd_sequencer u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hard_cmt_i   (hard_cmt),
    .soft_cmt_i   (soft_cmt),
    .spi_sel_i    (spi_sel),
    .dac_sel_i    (dac_sel),
    .status_ack_i (status_ack_i),
    .ec_rst_o     (ec_rst_o),
    .mac_reload_o (mac_reload_o),
    .spi_rst_o    (spi_rst_o),
    .dac_rst_o    (dac_rst_o),
    .status_req_o (status_req_o)
  );
endmodule

// File: rtl/rcd_checker.sv
module rcd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ec_rst_o,
  input logic       mac_reload_o,
  input logic       spi_rst_o,
  input logic       dac_rst_o,
  input logic       status_req_o,
  input logic       status_ack_i,
  input logic       hard_cmt,
  input logic       soft_cmt,
  input logic [7:0] location_o,
  input logic [7:0] debug_o
);
  AST_EC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) ec_rst_o |=> !ec_rst_o); // R2
  AST_HARD_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(ec_rst_o) |-> mac_reload_o); // R2
  AST_SPI_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) spi_rst_o |=> !spi_rst_o); // R4
  AST_DAC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) dac_rst_o |=> !dac_rst_o); // R4
  AST_SOFT_NO_EC: assert property (@(posedge clk_i) disable iff (!rst_ni) (spi_rst_o || dac_rst_o) |-> !ec_rst_o); // R4
  AST_STATUS_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni) (ec_rst_o || spi_rst_o || dac_rst_o) |=> status_req_o); // R5
  AST_STATUS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(status_req_o) |-> $past(hard_cmt || soft_cmt, 2)); // R5
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (status_req_o && !status_ack_i) |=> status_req_o); // R6
  AST_LOC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !(hard_cmt || soft_cmt) |=> $stable(location_o)); // R9
  AST_DBG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !soft_cmt |=> $stable(debug_o)); // R10
endmodule

bind rst_cmd_decoder rcd_checker u_chk (.*);

// File: tb/tb_rst_cmd_decoder.sv
`timescale 1ns/1ps
module tb_rst_cmd_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        valid_i = 1'b0, last_i = 1'b0, status_ack_i = 1'b0;
  logic        ec_rst_o, mac_reload_o, spi_rst_o, dac_rst_o, status_req_o;
  logic [7:0]  location_o, debug_o;
  logic [47:0] partner_mac_o;

  rst_cmd_decoder dut (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int cnt_ec, cnt_mr, cnt_spi, cnt_dac, strobe_cyc, rise_cyc, cmd_cyc;
  bit st_prev = 0;
  always @(negedge clk_i) begin
    cnt_ec  += int'(ec_rst_o);
    cnt_mr  += int'(mac_reload_o);
    cnt_spi += int'(spi_rst_o);
    cnt_dac += int'(dac_rst_o);
    if (ec_rst_o || spi_rst_o || dac_rst_o) strobe_cyc = cyc;
    if (status_req_o && !st_prev) rise_cyc = cyc;
    st_prev = status_req_o;
  end

  logic [7:0]  pkt [0:23];
  logic [7:0]  m_loc = '0, m_dbg = '0;
  logic [47:0] m_mac = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input int len, input int gap, input int cmd_idx);
    for (int i = 0; i < len; i++) begin
      if (i == gap) begin
        valid_i = 1'b0; last_i = 1'b0;
        @(negedge clk_i);
      end
      byte_i = pkt[i]; valid_i = 1'b1; last_i = (i == len - 1);
      if (i == cmd_idx) cmd_cyc = cyc;
      @(negedge clk_i);
    end
    valid_i = 1'b0; last_i = 1'b0; byte_i = 8'hxx;
  endtask

  // runs one packet and checks every output against the model
  task automatic run(input string tag, input int len, input int gap, input int cmd_idx,
                     input int e_ec, input int e_spi, input int e_dac, input bit e_st);
    cnt_ec = 0; cnt_mr = 0; cnt_spi = 0; cnt_dac = 0; strobe_cyc = -1; rise_cyc = -1; cmd_cyc = -100;
    send(len, gap, cmd_idx);
    repeat (3) @(negedge clk_i);
    chk({tag, " R2 ec count"}, cnt_ec, e_ec);
    chk({tag, " R2 reload count"}, cnt_mr, e_ec);
    chk({tag, " R4 spi count"}, cnt_spi, e_spi);
    chk({tag, " R4 dac count"}, cnt_dac, e_dac);
    chk({tag, " R5 status level"}, status_req_o, e_st);
    if (e_st) begin
      chk({tag, " R5 status rise cycle"}, rise_cyc, cmd_cyc + 2);
      if (e_ec + e_spi + e_dac > 0) chk({tag, " R2 R4 strobe cycle"}, strobe_cyc, cmd_cyc + 1);
    end
    chk({tag, " R9 location"}, location_o, m_loc);
    chk({tag, " R3 mac"}, partner_mac_o, m_mac);
    chk({tag, " R10 debug"}, debug_o, m_dbg);
    repeat (4) @(negedge clk_i);
    chk({tag, " R6 status held"}, status_req_o, e_st);
    status_ack_i = 1'b1;
    @(negedge clk_i);
    status_ack_i = 1'b0;
    chk({tag, " R6 status cleared"}, status_req_o, 1'b0);
  endtask

  function automatic logic [7:0] mac_oct(input int m, input int k);
    return 8'((m * 7 + k * 41 + 3) & 255);
  endfunction

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 strobes", {ec_rst_o, mac_reload_o, spi_rst_o, dac_rst_o}, 4'b0);
    chk("R1 status", status_req_o, 1'b0);
    chk("R1 location", location_o, 8'h0);
    chk("R1 mac", partner_mac_o, 48'h0);
    chk("R1 debug", debug_o, 8'h0);

    // R7 / R2 / R8: every type code in a two-byte payload
    for (int t = 0; t < 256; t++) begin
      pkt[0] = 8'(t) ^ 8'hA5; pkt[1] = 8'(t);
      if (t == 8'h52) begin
        m_loc = pkt[0];
        run("type sweep hard", 2, -1, 1, 1, 0, 0, 1);
      end else begin
        run("type sweep R7 R8", 2, -1, 1, 0, 0, 0, 0);
      end
    end

    // R3 R4 R10 R11: every mask value, bubbles at varying positions
    for (int m = 0; m < 256; m++) begin
      pkt[0] = 8'(m); pkt[1] = 8'hD2;
      for (int k = 0; k < 6; k++) pkt[2 + k] = mac_oct(m, k);
      pkt[8] = ~8'(m); pkt[9] = 8'(m);
      m_loc = 8'(m); m_dbg = ~8'(m);
      m_mac = '0;
      for (int k = 0; k < 6; k++) m_mac = (m_mac << 8) | 48'(mac_oct(m, k));
      run("mask sweep R4 R11", 10, (m % 3 == 0) ? (m % 10) : -1, 9,
          0, (m >> 1) & 1, m & 1, 1);
    end

    // R8: soft reset cut short at every point before the mask byte
    for (int len = 3; len <= 9; len++) begin
      pkt[0] = 8'(len + 8'h60); pkt[1] = 8'hD2;
      for (int k = 2; k < 10; k++) pkt[k] = 8'hFF;
      run("truncated R8", len, -1, -1, 0, 0, 0, 0);
    end

    // R11: hard reset with long tail repeating type codes (index saturates)
    pkt[0] = 8'h3C; pkt[1] = 8'h52;
    for (int k = 2; k < 24; k++) pkt[k] = (k % 2) ? 8'h52 : 8'hD2;
    m_loc = 8'h3C;
    run("hard tail R11", 24, 5, 1, 1, 0, 0, 1);

    // R11: soft reset with tail bytes after the mask
    pkt[0] = 8'h77; pkt[1] = 8'hD2;
    for (int k = 0; k < 6; k++) pkt[2 + k] = 8'(8'h10 * k + 8'h0A);
    pkt[8] = 8'h5E; pkt[9] = 8'h03;
    for (int k = 10; k < 24; k++) pkt[k] = 8'hD2;
    m_loc = 8'h77; m_dbg = 8'h5E; m_mac = 48'h0A1A2A3A4A5A;
    run("soft tail R11", 20, -1, 9, 0, 1, 1, 1);

    // R9: hard reset keeps the soft fields, updates location only
    pkt[0] = 8'h9B; pkt[1] = 8'h52; m_loc = 8'h9B;
    run("hard after soft R9", 2, -1, 1, 1, 0, 0, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule